// File: doc/BRIEF.md
# Selectable Power-of-Two Clock Divider

This block runs on a fast sampling clock and receives a slower clock as an oversampled digital waveform on `clk_in`. It drives two output banks. The pass-through bank is a registered, delayed copy of the input waveform. The divided bank has `NUM_DIV` identical outputs, each with a complement. The divided bank carries the input frequency divided by 2, 4, 8 or 16, with a 50% duty cycle counted in input periods. Both banks have the same latency in sampling-clock cycles for every ratio, so a rising edge on the divided bank always falls in the same cycle as the matching rising edge on the pass-through bank.

A 2-bit select chooses the ratio. The select is synchronised into the sampling domain before use. When the synchronised value changes, the divide counter restarts cleanly. A separate active-low divider reset parks the divided bank while the pass-through bank keeps running. The block has no data stream, so it has no valid/ready handshake: every pin is a plain level that is sampled on each clock, with no back-pressure.

Top module: `pow2_clk_divider`

## Requirements
- R1: Select code to ratio: 2'b00 divides by 2, 2'b01 by 4, 2'b10 by 8, 2'b11 by 16 (bit 0 is the LSB). Each divided period spans N input periods, with the output high for N/2 of them.
- R2: The divided outputs change level only in a cycle where the pass-through output rises. While running, the first divided rising edge after the divider leaves reset falls on the first input rising edge it processes.
- R3: `qa_n` is always the inverse of `qa`, and each `qb_n[i]` is always the inverse of `qb[i]`. Under `rst_n` low, `qa`=0, `qa_n`=1, `qb`=0 and `qb_n`=all ones.
- R4: A cycle sampled with `div_rst_n` low makes every `qb` 0 and every `qb_n` 1 from the next cycle on. It also clears the counter, so the divider starts from zero when released.
- R5: `qa` after clock edge k equals `clk_in` sampled at edge k-2, including while `div_rst_n` is low.
- R6: Matched latency: a divided rising edge appears in the same cycle as the pass-through rising edge produced by the same input edge, for every ratio.
- R7: All `qb` bits are equal in every cycle (zero skew).
- R8: `sel` passes through two synchroniser flops. When the synchronised value differs from the ratio in use, the counter clears and the divided level holds for that cycle. The next input rising edge then toggles the output under the new ratio, so no level lasts less than one input period.
- R9: Under `rst_n` the synchroniser and the active ratio load `DEF_SEL` (default 2'b11, divide by 16). A select held at 2'b11 through reset therefore causes no restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| div_rst_n | input | 1 | Synchronous active-low divider reset; the divided bank only |
| clk_in | input | 1 | Oversampled input clock waveform |
| sel | input | SEL_W | Ratio select, asynchronous to `clk` |
| qa | output | 1 | Pass-through output |
| qa_n | output | 1 | Complement of `qa` |
| qb | output | NUM_DIV | Divided outputs |
| qb_n | output | NUM_DIV | Complements of `qb` |

## Verification
The bench targets four corner cases.

- **Select change with the output high.** A design that cleared the level on a change would emit a runt high phase. One that kept the old count would stretch a phase beyond the new ratio.
- **Divider reset while the input keeps toggling.** A design that gated the shared sampling stage would freeze `qa`. One that released with a stale count would place the first divided edge off an input rising edge.
- **Input waveforms with unequal high and low lengths, including one-cycle phases.** These expose edge detection that keys on levels instead of transitions.
- **Each ratio measured over a long window.** This catches a swapped code map or an off-by-one terminal count.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  // one sampled view of the incoming clock waveform
  typedef struct packed {
    logic level;   // delayed level feeding the pass-through bank
    logic rise;    // one-cycle pulse on a detected rising edge
  } wave_sample_t;

  // counter terminal value (half period minus one) for a select code
  function automatic int unsigned half_limit(input int unsigned code);
    return (32'd1 << code) - 32'd1;
  endfunction

endpackage

// File: rtl/cd_sampler.sv
module cd_sampler
  import clkdiv_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clk_in,
  output wave_sample_t smp
);

  logic cur_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      cur_q  <= clk_in;
      prev_q <= cur_q;
    end
  end

  assign smp.level = prev_q;
  assign smp.rise  = cur_q & ~prev_q;

  // R5: the delayed level follows the first sample stage by exactly one cycle
  a_r5_level_follows: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (prev_q == $past(cur_q)));

endmodule

// File: rtl/cd_sel_sync.sv
module cd_sel_sync #(
  parameter int unsigned SEL_W   = 2,
  parameter logic [SEL_W-1:0] DEF_SEL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel_async,
  output logic [SEL_W-1:0] sel_act,
  output logic             sel_chg
);

  logic [SEL_W-1:0] meta_q, sync_q, act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= DEF_SEL;
      sync_q <= DEF_SEL;
      act_q  <= DEF_SEL;
    end else begin
      meta_q <= sel_async;
      sync_q <= meta_q;
      act_q  <= sync_q;
    end
  end

  assign sel_act = act_q;
  assign sel_chg = (sync_q != act_q);

  // R8: a flagged change is adopted as the active ratio one cycle later
  a_r8_change_adopted: assert property (@(posedge clk) disable iff (!rst_n)
    sel_chg |=> (act_q == $past(sync_q)));

endmodule

// File: rtl/cd_counter.sv
module cd_counter
  import clkdiv_pkg::*;
#(
  parameter int unsigned SEL_W = 2,
  localparam int unsigned CNT_W = (1 << SEL_W) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             div_rst_n,
  input  logic             rise,
  input  logic [SEL_W-1:0] sel_act,
  input  logic             sel_chg,
  output logic             div_lvl
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;
  logic             div_q;

  assign lim = CNT_W'(half_limit(32'(sel_act)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      div_q <= 1'b0;
    end else if (!div_rst_n) begin
      cnt_q <= '0;
      div_q <= 1'b0;
    end else if (sel_chg) begin
      cnt_q <= '0;
    end else if (rise) begin
      if (cnt_q == '0) div_q <= ~div_q;
      cnt_q <= (cnt_q == lim) ? '0 : cnt_q + 1'b1;
    end
  end

  assign div_lvl = div_q;

  // R2: the divided level moves only on a detected input rise
  a_r2_toggle_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(div_rst_n) && !$past(sel_chg) && (div_q != $past(div_q))) |-> $past(rise));

  // R8: a ratio change clears the count and holds the level
  a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_chg && div_rst_n) |=> ((cnt_q == '0) && $stable(div_q)));

  // R1: the count never passes the terminal value of the active ratio
  a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_chg |-> (cnt_q <= lim));

endmodule

// File: rtl/cd_outreg.sv
module cd_outreg #(
  parameter int unsigned NUM_DIV = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               div_rst_n,
  input  logic               pass_lvl,
  input  logic               div_lvl,
  output logic               qa,
  output logic               qa_n,
  output logic [NUM_DIV-1:0] qb,
  output logic [NUM_DIV-1:0] qb_n
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qa   <= 1'b0;
      qa_n <= 1'b1;
    end else begin
      qa   <= pass_lvl;
      qa_n <= ~pass_lvl;
    end
  end

  for (genvar i = 0; i < NUM_DIV; i++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        qb[i]   <= 1'b0;
        qb_n[i] <= 1'b1;
      end else if (!div_rst_n) begin
        qb[i]   <= 1'b0;
        qb_n[i] <= 1'b1;
      end else begin
        qb[i]   <= div_lvl;
        qb_n[i] <= ~div_lvl;
      end
    end
  end

  // R4: a sampled divider reset parks the whole divided bank next cycle
  a_r4_reset_parks: assert property (@(posedge clk) disable iff (!rst_n)
    !div_rst_n |=> ((qb == '0) && (qb_n == '1)));

  // R5: pass-through keeps following its source even under divider reset
  a_r5_pass_runs: assert property (@(posedge clk) disable iff (!rst_n)
    !div_rst_n |=> (qa == $past(pass_lvl)));

endmodule

// File: rtl/pow2_clk_divider.sv
module pow2_clk_divider
  import clkdiv_pkg::*;
#(
  parameter int unsigned      NUM_DIV = 2,
  parameter int unsigned      SEL_W   = 2,
  parameter logic [SEL_W-1:0] DEF_SEL = 2'b11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               div_rst_n,
  input  logic               clk_in,
  input  logic [SEL_W-1:0]   sel,
  output logic               qa,
  output logic               qa_n,
  output logic [NUM_DIV-1:0] qb,
  output logic [NUM_DIV-1:0] qb_n
);

  wave_sample_t     smp;
  logic [SEL_W-1:0] sel_act;
  logic             sel_chg;
  logic             div_lvl;

  cd_sampler u_smp (
    .clk    (clk),
    .rst_n  (rst_n),
    .clk_in (clk_in),
    .smp    (smp)
  );

  cd_sel_sync #(.SEL_W(SEL_W), .DEF_SEL(DEF_SEL)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_async (sel),
    .sel_act   (sel_act),
    .sel_chg   (sel_chg)
  );

  cd_counter #(.SEL_W(SEL_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .div_rst_n (div_rst_n),
    .rise      (smp.rise),
    .sel_act   (sel_act),
    .sel_chg   (sel_chg),
    .div_lvl   (div_lvl)
  );

  cd_outreg #(.NUM_DIV(NUM_DIV)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .div_rst_n (div_rst_n),
    .pass_lvl  (smp.level),
    .div_lvl   (div_lvl),
    .qa        (qa),
    .qa_n      (qa_n),
    .qb        (qb),
    .qb_n      (qb_n)
  );

  // R6: a divided rising edge coincides with a pass-through rising edge
  a_r6_matched_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (qb[0] && !$past(qb[0])) |-> (qa && !$past(qa)));

  // R7: every divided output carries the same level
  a_r7_bank_equal: assert property (@(posedge clk) disable iff (!rst_n)
    (qb == {NUM_DIV{qb[0]}}));

endmodule

// File: tb/sim_pow2_clk_divider.sv
module sim_pow2_clk_divider;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_DIV    = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic div_rst_n = 1'b1;
  logic clk_in = 1'b0;
  logic [1:0] sel = 2'b11;
  logic qa, qa_n;
  logic [NUM_DIV-1:0] qb, qb_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pow2_clk_divider #(.NUM_DIV(NUM_DIV), .SEL_W(2), .DEF_SEL(2'b11)) u0 (
    .clk(clk), .rst_n(rst_n), .div_rst_n(div_rst_n), .clk_in(clk_in),
    .sel(sel), .qa(qa), .qa_n(qa_n), .qb(qb), .qb_n(qb_n));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // input waveform generator: gen_hi cycles high, gen_lo cycles low
  int gen_hi = 2, gen_lo = 2, gen_ph = 0;
  always @(negedge clk) begin
    gen_ph++;
    if (clk_in && gen_ph >= gen_hi) begin clk_in <= 1'b0; gen_ph = 0; end
    else if (!clk_in && gen_ph >= gen_lo) begin clk_in <= 1'b1; gen_ph = 0; end
  end

  // behavioural reference
  bit hist[$];
  bit sel_pipe[$];
  int sel_hist[$];
  int act_ratio = 3;
  int rise_cnt = 0;
  bit lvl = 0;
  bit e_qa = 0, e_qb = 0;
  int since_chg = 100, since_rst = 0, since_drst = 100;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = '{0, 0, 0};
      sel_hist = '{3, 3};
      act_ratio = 3; rise_cnt = 0; lvl = 0; e_qa = 0; e_qb = 0;
      since_chg = 100; since_rst = 0;
    end else begin
      bit in_rise;
      bit chg;
      bit old_lvl;
      old_lvl = lvl;
      in_rise = hist[0] && !hist[1];
      chg = (sel_hist[1] != act_ratio);
      e_qa = hist[1];
      e_qb = div_rst_n ? old_lvl : 1'b0;
      if (!div_rst_n) begin rise_cnt = 0; lvl = 0; end
      else if (chg) rise_cnt = 0;
      else if (in_rise) begin
        if (rise_cnt == 0) lvl = !lvl;
        rise_cnt = (rise_cnt + 1) % (1 << act_ratio);
      end
      act_ratio = sel_hist[1];
      sel_hist.push_front(int'(sel));
      void'(sel_hist.pop_back());
      hist.push_front(clk_in);
      void'(hist.pop_back());
      since_chg = chg ? 0 : since_chg + 1;
      since_drst = !div_rst_n ? 0 : since_drst + 1;
      since_rst++;
    end
  end

  // per-cycle comparison away from the active edge
  bit prev_qa = 0, prev_qb = 0;
  int qa_rises = 0, qb_rises = 0, qa_toggles = 0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      string tag;
      check(qa == e_qa, "R5", qa, e_qa);
      check(qa_n == !qa, "R3", qa_n, !qa);
      tag = (since_drst < 3) ? "R4" : (since_chg < 40) ? "R8" : (since_rst < 60) ? "R9" : "R1";
      check(qb[0] == e_qb, tag, qb[0], e_qb);
      for (int i = 0; i < NUM_DIV; i++) begin
        check(qb[i] == qb[0], "R7", qb[i], qb[0]);
        check(qb_n[i] == !qb[i], "R3", qb_n[i], !qb[i]);
      end
      if (qb[0] && !prev_qb) check(qa && !prev_qa, "R6", qa, 1);
      if (!qb[0] && prev_qb && div_rst_n && since_drst > 1) check(qa && !prev_qa, "R2", qa, 1);
      if (qa && !prev_qa) qa_rises++;
      if (qb[0] && !prev_qb) qb_rises++;
      if (qa != prev_qa) qa_toggles++;
      prev_qa = qa; prev_qb = qb[0];
    end
  end

  task automatic measure(input int code, input int hi, input int lo);
    int n;
    int diff;
    n = 1 << (code + 1);
    @(negedge clk);
    sel = 2'(code); gen_hi = hi; gen_lo = lo;
    repeat (60) @(negedge clk);
    qa_rises = 0; qb_rises = 0;
    repeat ((hi + lo) * n * 6) @(negedge clk);
    diff = qa_rises - n * qb_rises;
    if (diff < 0) diff = -diff;
    check(diff <= n, "R1", qb_rises, qa_rises / n);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(qa == 0 && qa_n == 1, "R3", {qa, qa_n}, 1);
    check(qb == '0 && qb_n == '1, "R3", {qb, qb_n}, 3);
    rst_n = 1'b1;
    // default ratio from reset: R9
    qa_rises = 0; qb_rises = 0;
    repeat (4 * 16 * 4) @(negedge clk);
    check(qb_rises >= 3 && qb_rises <= 5, "R9", qb_rises, 4);
    measure(0, 1, 1);
    measure(1, 2, 3);
    measure(2, 3, 2);
    measure(3, 2, 2);
    measure(0, 1, 4);
    // divider reset: pass-through keeps running (R5), bank parks (R4)
    sel = 2'b01; gen_hi = 2; gen_lo = 2;
    repeat (50) @(negedge clk);
    div_rst_n = 1'b0;
    qa_toggles = 0;
    repeat (30) @(negedge clk);
    check(qa_toggles >= 10, "R5", qa_toggles, 14);
    check(qb == '0 && qb_n == '1, "R4", qb, 0);
    div_rst_n = 1'b1;
    repeat (60) @(negedge clk);
    // select changes with the output in both levels (R8)
    for (int k = 0; k < 12; k++) begin
      sel = 2'(k % 4);
      repeat (7 + 3 * k) @(negedge clk);
    end
    sel = 2'b11;
    repeat (200) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule